// File: doc/BRIEF.md
# Cartridge RAM Bank Mapper

This block sits on the cartridge side of an 8-bit processor bus with a 13-bit address space. It maps one of several on-cartridge RAM banks into a 2K slot at $1000-$17FF. The slot is split into two halves that point at the same 1K of RAM. The lower half ($1000-$13FF) is read-only and the upper half ($1400-$17FF) is write-only. A bus write to $003E selects the bank. The RAM itself is an external single-port synchronous array reached through a dedicated port. Its address is the bank number concatenated with the 10-bit offset.

The processor has no separate write strobe for this slot, so any read cycle that lands in the write half still stores a byte. This includes the dummy fetches the processor issues on its own. The block models that unintended store on purpose. In bus-hold mode the stored byte is the last value seen on the data bus. In random mode it comes from a table of 256 fixed pseudo-random bytes, indexed by the low eight offset bits. A linear feedback shift register fills that table during a 256-cycle sequence after each reset, so the values are the same from one reset to the next.

Each clock edge ends one bus cycle. Read data for a read-half cycle is driven in the following cycle, when the synchronous RAM returns it. No data path here carries back-pressure: the processor bus cannot stall, so every cycle is accepted as it comes and there is no valid/ready pairing.

Top module: `cartmap_ram_mapper`

## Requirements
- R1: After reset is released, the bank register is 0. For the first 256 clocks the table is being filled: every bus cycle is ignored, with no RAM write, no output enable and no bank load.
- R2: A write cycle (cpu_rd=0) to address $003E loads cpu_din[2:0] as the bank number. That cycle asserts neither ram_we nor cpu_doe.
- R3: A write cycle to $1400+n (n in 0..$3FF) asserts ram_we in the same cycle, with ram_addr = {bank, n} and ram_wdata = cpu_din.
- R4: A read cycle to $1000+n drives ram_addr = {bank, n} with ram_we low. In the next cycle cpu_doe is 1 and cpu_dout is that RAM byte. Repeated reads leave the byte unchanged.
- R5: cpu_doe is 1 only in the cycle after a read-half read. In every other cycle it is 0 and cpu_dout is 0.
- R6: A read cycle to $1400+n asserts ram_we in that cycle with ram_addr = {bank, n}. In bus-hold mode (subst_random=0) ram_wdata is the last bus value.
- R7: In random mode (subst_random=1) the byte stored by a write-half read is T[n mod 256]. Here T[0] is the SEED parameter (default $A5) and T[i+1] = {T[i][6:0], T[i][7]^T[i][5]^T[i][4]^T[i][3]}. The values are identical after every reset.
- R8: Banks are isolated: bytes stored at the same offset in different banks do not affect each other.
- R9: A read of $13FF followed at once by a read of $1400 in bus-hold mode stores the byte just returned from $13FF into RAM byte 0 of the bank.
- R10: Cycles outside the slot, and writes to the read half, assert neither ram_we nor cpu_doe.
- R11: The last bus value is cpu_din after a write cycle, or after a read of any address outside the slot. After a read-half read it is the returned RAM byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock; each rising edge ends a cycle |
| rst_n | input | 1 | Active-low reset; starts the table fill |
| cpu_addr | input | 13 | Bus address |
| cpu_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| cpu_din | input | 8 | Data bus as driven by others (processor on writes, other devices on reads) |
| cpu_dout | output | 8 | Read-half data, valid while cpu_doe is 1 |
| cpu_doe | output | 1 | Output enable for cpu_dout |
| subst_random | input | 1 | 0 = bus-hold substitution, 1 = table substitution |
| ram_addr | output | 13 | RAM array address {bank, offset} |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after the address |

## Verification
Two functions can land in the same cycle: returning the data of a read-half read, and committing the forced store of a write-half read. The bench provokes this by reading $13FF and then $1400 on the very next cycle. In that cycle it expects cpu_doe high with the $13FF byte, and ram_we high at {bank, 0} carrying that same byte. It then reads offset 0 back through the read half to confirm that the byte was corrupted.

// File: rtl/cartmap_pkg.sv
package cartmap_pkg;

  typedef enum logic [1:0] {
    CYC_OTHER   = 2'd0,
    CYC_BANKSEL = 2'd1,
    CYC_RDHALF  = 2'd2,
    CYC_WRHALF  = 2'd3
  } cyc_kind_e;

  // 8-bit maximal-length shift register step, taps 8,6,5,4
  function automatic logic [7:0] lfsr8_step(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

endpackage

// File: rtl/cartmap_decode.sv
module cartmap_decode
  import cartmap_pkg::*;
#(
  parameter int          ADDR_W    = 13,
  parameter int          OFS_W     = 10,
  parameter logic [12:0] SLOT_BASE = 13'h1000,
  parameter logic [12:0] SEL_ADDR  = 13'h003E
) (
  input  logic [ADDR_W-1:0] addr,
  output cyc_kind_e         kind,
  output logic [OFS_W-1:0]  ofs
);

  localparam int HI = ADDR_W - 1;
  localparam int LO = OFS_W + 1;

  logic in_slot;

  always_comb begin
    in_slot = (addr[HI:LO] == SLOT_BASE[HI:LO]);
    ofs     = addr[OFS_W-1:0];
    if (addr == SEL_ADDR[ADDR_W-1:0])
      kind = CYC_BANKSEL;
    else if (in_slot && !addr[OFS_W])
      kind = CYC_RDHALF;
    else if (in_slot)
      kind = CYC_WRHALF;
    else
      kind = CYC_OTHER;
  end

endmodule

// File: rtl/cartmap_subst_table.sv
module cartmap_subst_table
  import cartmap_pkg::*;
#(
  parameter int         IDX_W = 8,
  parameter logic [7:0] SEED  = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       value,
  output logic             busy
);

  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W:0] fill_cnt;
  logic [7:0]     lfsr_q;
  logic [7:0]     tbl [DEPTH];

  assign busy = !fill_cnt[IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      lfsr_q   <= SEED;
    end else if (busy) begin
      fill_cnt <= fill_cnt + 1'b1;
      lfsr_q   <= lfsr8_step(lfsr_q);
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (busy && fill_cnt[IDX_W-1:0] == IDX_W'(i))
          tbl[i] <= lfsr_q;
      end
    end
  endgenerate

  assign value = tbl[idx];

  // the fill runs once per reset
  AST_FILL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy); // R1

endmodule

// File: rtl/cartmap_bank_reg.sv
module cartmap_bank_reg #(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] d,
  output logic [BANK_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= d;
  end

  AST_BANK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R2

endmodule

// File: rtl/cartmap_ram_mapper.sv
module cartmap_ram_mapper
  import cartmap_pkg::*;
#(
  parameter int         BANK_W = 3,
  parameter int         OFS_W  = 10,
  parameter int         IDX_W  = 8,
  parameter logic [7:0] SEED   = 8'hA5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [12:0]             cpu_addr,
  input  logic                    cpu_rd,
  input  logic [7:0]              cpu_din,
  output logic [7:0]              cpu_dout,
  output logic                    cpu_doe,
  input  logic                    subst_random,
  output logic [BANK_W+OFS_W-1:0] ram_addr,
  output logic                    ram_we,
  output logic [7:0]              ram_wdata,
  input  logic [7:0]              ram_rdata
);

  localparam int RAM_AW = BANK_W + OFS_W;

  cyc_kind_e          kind;
  logic [OFS_W-1:0]   ofs;
  logic [BANK_W-1:0]  bank_q;
  logic               fill_busy;
  logic [7:0]         tbl_val;
  logic               active;
  logic               doe_q;
  logic [7:0]         hold_q;
  logic [7:0]         last_bus;
  logic [7:0]         subst_val;

  cartmap_decode #(.ADDR_W(13), .OFS_W(OFS_W)) u_dec (
    .addr (cpu_addr),
    .kind (kind),
    .ofs  (ofs)
  );

  cartmap_subst_table #(.IDX_W(IDX_W), .SEED(SEED)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .idx   (ofs[IDX_W-1:0]),
    .value (tbl_val),
    .busy  (fill_busy)
  );

  cartmap_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (active && kind == CYC_BANKSEL && !cpu_rd),
    .d     (cpu_din[BANK_W-1:0]),
    .q     (bank_q)
  );

  assign active = !fill_busy;

  // value the bus carried in the previous cycle
  assign last_bus  = doe_q ? ram_rdata : hold_q;
  assign subst_val = subst_random ? tbl_val : last_bus;

  always_comb begin
    ram_addr  = RAM_AW'({bank_q, ofs});
    ram_we    = active && kind == CYC_WRHALF;
    ram_wdata = cpu_rd ? subst_val : cpu_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doe_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      doe_q <= active && kind == CYC_RDHALF && cpu_rd;
      if (active) begin
        if (cpu_rd && (kind == CYC_RDHALF || kind == CYC_WRHALF))
          hold_q <= last_bus;
        else
          hold_q <= cpu_din;
      end
    end
  end

  assign cpu_doe  = doe_q;
  assign cpu_dout = doe_q ? ram_rdata : 8'h00;

  AST_QUIET_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> (!ram_we && !cpu_doe)); // R1

  AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_doe |-> $past(cpu_rd && cpu_addr[12:11] == 2'b10 && !cpu_addr[10])); // R5

  AST_WE_IN_WRHALF: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_addr[12:11] == 2'b10 && cpu_addr[10])); // R10

  AST_PEEK_CARRIES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && cpu_rd && !subst_random && cpu_doe) |-> ram_wdata == cpu_dout); // R9

endmodule

// File: tb/cartmap_ram_mapper_tb.sv
module cartmap_ram_mapper_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] cpu_addr = 13'h0080;
  logic        cpu_rd = 1'b1;
  logic [7:0]  cpu_din = 8'h00;
  logic [7:0]  cpu_dout;
  logic        cpu_doe;
  logic        subst_random = 1'b0;
  logic [12:0] ram_addr;
  logic        ram_we;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;

  logic [7:0]  mem [8192];
  int          n_chk = 0;
  int          n_bad = 0;

  logic        s_we, s_doe;
  logic [12:0] s_addr;
  logic [7:0]  s_wd, s_dout;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  cartmap_ram_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_din(cpu_din), .cpu_dout(cpu_dout), .cpu_doe(cpu_doe),
    .subst_random(subst_random), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [12:0] a, input logic rd, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_din = d;
    #1;
    s_we = ram_we; s_addr = ram_addr; s_wd = ram_wdata;
    s_doe = cpu_doe; s_dout = cpu_dout;
  endtask

  function automatic logic [7:0] tbl_ref(input int idx);
    logic [7:0] s = 8'hA5;
    for (int i = 0; i < idx; i++) s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_fill();
    do_reset();
    cyc(13'h003E, 1'b0, 8'h05);
    check(!s_we, "R1 we in fill", s_we, 0);
    cyc(13'h1407, 1'b0, 8'hAA);
    check(!s_we, "R1 we in fill", s_we, 0);
    cyc(13'h1007, 1'b1, 8'h00);
    cyc(13'h0080, 1'b1, 8'h00);
    check(!s_doe, "R1 doe in fill", s_doe, 0);
    repeat (260) cyc(13'h0080, 1'b1, 8'h00);
    cyc(13'h1407, 1'b0, 8'h11);
    check(s_we && s_addr == 13'h0007, "R1 bank 0 after reset", s_addr, 13'h0007);
  endtask

  task automatic t_select_write_read();
    cyc(13'h003E, 1'b0, 8'h02);
    check(!s_we, "R2 no we on select", s_we, 0);
    cyc(13'h1405, 1'b0, 8'h5A);
    check(!s_doe, "R2 no doe after select", s_doe, 0);
    check(s_we && s_addr == {3'd2, 10'h005} && s_wd == 8'h5A, "R3 write half",
          {s_we, s_addr, s_wd}, {1'b1, 3'd2, 10'h005, 8'h5A});
    cyc(13'h1005, 1'b1, 8'hEE);
    check(!s_we && s_addr == {3'd2, 10'h005}, "R4 read addr", s_addr, {3'd2, 10'h005});
    cyc(13'h1005, 1'b1, 8'hEE);
    check(s_doe && s_dout == 8'h5A, "R4 read data", s_dout, 8'h5A);
    check(!s_we, "R4 no we on reread", s_we, 0);
    cyc(13'h0080, 1'b1, 8'h00);
    check(s_doe && s_dout == 8'h5A, "R4 unchanged", s_dout, 8'h5A);
    cyc(13'h0080, 1'b1, 8'h00);
    check(!s_doe && s_dout == 8'h00, "R5 doe low after other", s_dout, 0);
  endtask

  task automatic t_isolation();
    cyc(13'h003E, 1'b0, 8'h03);
    cyc(13'h1405, 1'b0, 8'h33);
    cyc(13'h003E, 1'b0, 8'h02);
    cyc(13'h1005, 1'b1, 8'h00);
    cyc(13'h0080, 1'b1, 8'h00);
    check(s_doe && s_dout == 8'h5A, "R8 bank 2 kept", s_dout, 8'h5A);
    cyc(13'h003E, 1'b0, 8'h03);
    cyc(13'h1005, 1'b1, 8'h00);
    cyc(13'h0080, 1'b1, 8'h00);
    check(s_doe && s_dout == 8'h33, "R8 bank 3 kept", s_dout, 8'h33);
  endtask

  task automatic t_outside();
    cyc(13'h0800, 1'b1, 8'h12);
    check(!s_we, "R10 outside read", s_we, 0);
    cyc(13'h1800, 1'b0, 8'h12);
    check(!s_we && !s_doe, "R10 outside write", {s_we, s_doe}, 0);
    cyc(13'h1005, 1'b0, 8'h77);
    check(!s_we, "R10 write to read half", s_we, 0);
    cyc(13'h1005, 1'b1, 8'h00);
    cyc(13'h0080, 1'b1, 8'h00);
    check(s_dout == 8'h33, "R10 read half unchanged", s_dout, 8'h33);
  endtask

  task automatic t_bus_hold();
    subst_random = 1'b0;
    cyc(13'h0080, 1'b1, 8'hC7);
    cyc(13'h1410, 1'b1, 8'h00);
    check(s_we && s_addr == {3'd3, 10'h010} && s_wd == 8'hC7, "R6 R11 hold from read",
          {s_addr, s_wd}, {3'd3, 10'h010, 8'hC7});
    cyc(13'h1420, 1'b0, 8'h21);
    cyc(13'h1430, 1'b1, 8'h00);
    check(s_we && s_wd == 8'h21, "R11 hold from write", s_wd, 8'h21);
    cyc(13'h003E, 1'b0, 8'h02);
    cyc(13'h1400, 1'b1, 8'hFF);
    check(s_we && s_addr == {3'd2, 10'h000} && s_wd == 8'h02, "R6 hold from select",
          {s_addr, s_wd}, {3'd2, 10'h000, 8'h02});
  endtask

  task automatic t_dummy_peek();
    cyc(13'h003E, 1'b0, 8'h01);
    cyc(13'h17FF, 1'b0, 8'h9E);
    cyc(13'h1400, 1'b0, 8'h44);
    cyc(13'h13FF, 1'b1, 8'hEE);
    cyc(13'h1400, 1'b1, 8'hEE);
    check(s_doe && s_dout == 8'h9E, "R9 data returns", s_dout, 8'h9E);
    check(s_we && s_addr == {3'd1, 10'h000} && s_wd == 8'h9E, "R9 dummy store",
          {s_addr, s_wd}, {3'd1, 10'h000, 8'h9E});
    cyc(13'h1000, 1'b1, 8'h00);
    cyc(13'h0080, 1'b1, 8'h00);
    check(s_dout == 8'h9E, "R9 byte 0 corrupted", s_dout, 8'h9E);
  endtask

  task automatic t_random(input string tag);
    int offs [4] = '{0, 1, 'h37, 'h1FF};
    subst_random = 1'b1;
    foreach (offs[k]) begin
      cyc(13'h0080, 1'b1, 8'h5C);
      cyc(13'h1400 + 13'(offs[k]), 1'b1, 8'h00);
      check(s_we && s_wd == tbl_ref(offs[k] % 256), tag, s_wd, tbl_ref(offs[k] % 256));
    end
    subst_random = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
    t_reset_fill();
    t_select_write_read();
    t_isolation();
    t_outside();
    t_bus_hold();
    t_dummy_peek();
    t_random("R7 random table");
    t_reset_fill();
    t_random("R7 repeat after reset");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule